// File: doc/BRIEF.md
# Variable-Page Translation Buffer

This block translates effective addresses into physical addresses with a small fully associative table. Every entry maps a single virtual page onto a physical page. Each entry carries its own page size, chosen from nine sizes between 4 KB and 256 MB, with each step four times the last. The page size decides how many upper address bits take part in the compare and how many are replaced in the result. The bits below the page boundary pass through unchanged as the offset.

A lookup supplies an effective address and an instruction/data flag. It also supplies two address-space bits, one for instruction fetches and one for data accesses, and a process ID. The flag selects which address-space bit must equal the entry's space bit. An entry whose owner ID is zero matches every process. All entries are compared in parallel. One registered stage returns the result a cycle later: a hit flag, the physical address, the winning entry's index and its permission bits, or an instruction-miss or data-miss indication.

Software or a refill engine loads entries through a write port addressed by index. Permission enforcement, table walking and victim selection are left to the surrounding logic.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, rsp_valid is 0, and any lookup misses.
- R2: A lookup presented with req_valid high at a rising edge gives rsp_valid high for exactly the following cycle. A cycle without a request gives rsp_valid low in the next cycle.
- R3: An entry with size code s (0 to 8) compares effective-address bits 31 down to 12+2s with the same bits of its page number. Size codes above 8 act as 8 (256 MB).
- R4: On a hit, physical address bits 31 down to 12+2s come from the entry's real page number and the lower bits come from the effective address. Real page number bits below the page boundary are ignored.
- R5: An entry matches only if its space bit equals req_inst_as when req_instr is 1, or req_data_as when req_instr is 0.
- R6: An entry matches only if its owner ID equals req_pid, except that an owner ID of 0 matches any req_pid.
- R7: When no entry matches, rsp_imiss is raised if req_instr was 1 and rsp_dmiss is raised if it was 0. Exactly one of rsp_hit, rsp_imiss and rsp_dmiss is high on every response.
- R8: If several entries match, the lowest index wins and rsp_multi is raised. With a single match rsp_multi is 0.
- R9: A write with wr_en high at a rising edge replaces entry wr_idx completely. A lookup in the same cycle still sees the entry as it was before the write.
- R10: An entry written with wr_valid 0 never matches.
- R11: On a hit, rsp_perm returns the winning entry's 6-bit permission field unchanged. On a miss, rsp_pa and rsp_perm are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | 5 | Entry index to load |
| wr_valid | input | 1 | Valid bit of the loaded entry |
| wr_ts | input | 1 | Address-space bit of the loaded entry |
| wr_tid | input | 8 | Owner process ID (0 = any) |
| wr_size | input | 4 | Page size code, size = 4 KB * 4^code |
| wr_epn | input | 20 | Virtual page number (address bits 31:12) |
| wr_rpn | input | 20 | Real page number (address bits 31:12) |
| wr_perm | input | 6 | Permission bits returned on a hit |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| req_inst_as | input | 1 | Address-space bit for instruction fetches |
| req_data_as | input | 1 | Address-space bit for data accesses |
| req_pid | input | 8 | Current process ID |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Translation found |
| rsp_imiss | output | 1 | Instruction lookup missed |
| rsp_dmiss | output | 1 | Data lookup missed |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_idx | output | 5 | Index of the winning entry |
| rsp_pa | output | 32 | Physical address |
| rsp_perm | output | 6 | Permission bits of the winning entry |

## Verification
A table load and a lookup can fall in the same cycle. When they do, the lookup must be judged against the table as it stood before the load. The bench provokes this by driving a load of an entry that is about to hit together with a lookup of that entry's address. It expects the old real page number in that response and the new one in the following response. Overlapping entries are also loaded so that two matches land in one lookup, and the bench checks which entry wins and that rsp_multi is raised.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int ADDR_W   = 32;
  parameter int PG_LSB   = 12;
  parameter int ID_W     = 8;
  parameter int SZ_W     = 4;
  parameter int PERM_W   = 6;
  parameter int MAX_SZ   = 8;
  localparam int PN_W    = ADDR_W - PG_LSB;

  typedef struct packed {
    logic              valid;
    logic              ts;
    logic [ID_W-1:0]   tid;
    logic [SZ_W-1:0]   size;
    logic [PN_W-1:0]   epn;
    logic [PN_W-1:0]   rpn;
    logic [PERM_W-1:0] perm;
  } tlb_entry_t;

  // Page-number bits that take part in compare/replace for a size code
  function automatic logic [PN_W-1:0] size_mask(input logic [SZ_W-1:0] code);
    int unsigned s;
    s = (int'(code) > MAX_SZ) ? MAX_SZ : int'(code);
    return {PN_W{1'b1}} << (2 * s);
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_entry_t       wr_data,
  output tlb_entry_t       ent [ENTRIES]
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic       ld;
    tlb_entry_t ent_q;

    always_comb begin
      ld = wr_en && (wr_idx == IDX_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ld) begin
        ent_q <= wr_data;
      end
    end

    assign ent[i] = ent_q;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent[$past(wr_idx)] == $past(wr_data)); // R9

endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  tlb_entry_t        ent [ENTRIES],
  input  logic [ADDR_W-1:0] ea,
  input  logic              as_bit,
  input  logic [ID_W-1:0]   pid,
  output logic [ENTRIES-1:0] hit_vec
);

  logic [PN_W-1:0] ea_pn;
  assign ea_pn = ea[ADDR_W-1:PG_LSB];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [PN_W-1:0] m;
    logic            pn_ok, id_ok, sp_ok;

    always_comb begin
      m       = size_mask(ent[i].size);
      pn_ok   = ((ea_pn ^ ent[i].epn) & m) == '0;
      id_ok   = (ent[i].tid == '0) || (ent[i].tid == pid);
      sp_ok   = ent[i].ts == as_bit;
      hit_vec[i] = ent[i].valid && pn_ok && id_ok && sp_ok;
    end
  end

endmodule

// File: rtl/tlb_select.sv
module tlb_select
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  tlb_entry_t         ent [ENTRIES],
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic [ADDR_W-1:0]  ea,
  output logic               found,
  output logic               multi,
  output logic [IDX_W-1:0]   idx,
  output logic [ADDR_W-1:0]  pa,
  output logic [PERM_W-1:0]  perm
);

  tlb_entry_t      sel;
  logic [PN_W-1:0] m;

  // lowest index has priority
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    found = |hit_vec;
    multi = (hit_vec & (hit_vec - ENTRIES'(1))) != '0;
    sel   = ent[idx];
    m     = size_mask(sel.size);
    if (found) begin
      pa   = {(sel.rpn & m) | (ea[ADDR_W-1:PG_LSB] & ~m), ea[PG_LSB-1:0]};
      perm = sel.perm;
    end else begin
      pa   = '0;
      perm = '0;
    end
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_ts,
  input  logic [ID_W-1:0]   wr_tid,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic [PN_W-1:0]   wr_epn,
  input  logic [PN_W-1:0]   wr_rpn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_ea,
  input  logic              req_instr,
  input  logic              req_inst_as,
  input  logic              req_data_as,
  input  logic [ID_W-1:0]   req_pid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_imiss,
  output logic              rsp_dmiss,
  output logic              rsp_multi,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic [PERM_W-1:0] rsp_perm
);

  tlb_entry_t         wr_data;
  tlb_entry_t         ent [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic               as_sel;
  logic               found_d, multi_d;
  logic [IDX_W-1:0]   idx_d;
  logic [ADDR_W-1:0]  pa_d;
  logic [PERM_W-1:0]  perm_d;

  logic               vld_q, hit_q, multi_q, instr_q;
  logic [IDX_W-1:0]   idx_q;
  logic [ADDR_W-1:0]  pa_q;
  logic [PERM_W-1:0]  perm_q;

  always_comb begin
    wr_data = '{valid: wr_valid, ts: wr_ts, tid: wr_tid, size: wr_size,
                epn: wr_epn, rpn: wr_rpn, perm: wr_perm};
    as_sel  = req_instr ? req_inst_as : req_data_as;
  end

  tlb_entry_array #(.ENTRIES(ENTRIES)) i_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ent     (ent)
  );

  tlb_match #(.ENTRIES(ENTRIES)) i_match (
    .ent     (ent),
    .ea      (req_ea),
    .as_bit  (as_sel),
    .pid     (req_pid),
    .hit_vec (hit_vec)
  );

  tlb_select #(.ENTRIES(ENTRIES)) i_select (
    .ent     (ent),
    .hit_vec (hit_vec),
    .ea      (req_ea),
    .found   (found_d),
    .multi   (multi_d),
    .idx     (idx_d),
    .pa      (pa_d),
    .perm    (perm_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      multi_q <= 1'b0;
      instr_q <= 1'b0;
      idx_q   <= '0;
      pa_q    <= '0;
      perm_q  <= '0;
    end else if (req_valid) begin
      hit_q   <= found_d;
      multi_q <= multi_d;
      instr_q <= req_instr;
      idx_q   <= idx_d;
      pa_q    <= pa_d;
      perm_q  <= perm_d;
    end
  end

  always_comb begin
    rsp_valid = vld_q;
    rsp_hit   = vld_q & hit_q;
    rsp_imiss = vld_q & ~hit_q & instr_q;
    rsp_dmiss = vld_q & ~hit_q & ~instr_q;
    rsp_multi = vld_q & multi_q;
    rsp_idx   = idx_q;
    rsp_pa    = pa_q;
    rsp_perm  = perm_q;
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_imiss, rsp_dmiss}) == 1); // R7
  AST_MISS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_instr) |=> !rsp_dmiss); // R7
  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && rsp_perm == '0)); // R11
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_pa[PG_LSB-1:0] == $past(req_ea[PG_LSB-1:0]))); // R4

endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_valid, wr_ts;
  logic [4:0]  wr_idx;
  logic [7:0]  wr_tid;
  logic [3:0]  wr_size;
  logic [19:0] wr_epn, wr_rpn;
  logic [5:0]  wr_perm;
  logic        req_valid, req_instr, req_inst_as, req_data_as;
  logic [31:0] req_ea;
  logic [7:0]  req_pid;
  logic        rsp_valid, rsp_hit, rsp_imiss, rsp_dmiss, rsp_multi;
  logic [4:0]  rsp_idx;
  logic [31:0] rsp_pa;
  logic [5:0]  rsp_perm;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  tlb_xlate i_tlb_xlate (.*);

  // bench model of the table
  bit          m_v   [32];
  bit          m_ts  [32];
  logic [7:0]  m_tid [32];
  logic [3:0]  m_sz  [32];
  logic [19:0] m_epn [32];
  logic [19:0] m_rpn [32];
  logic [5:0]  m_pm  [32];

  typedef struct {
    bit          hit;
    logic [31:0] pa;
    logic [5:0]  perm;
    logic [4:0]  idx;
    bit          im, dm, multi;
    string       tag;
  } exp_t;

  exp_t sbq [$];

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic commit();
    m_v[wr_idx]   = wr_valid;
    m_ts[wr_idx]  = wr_ts;
    m_tid[wr_idx] = wr_tid;
    m_sz[wr_idx]  = wr_size;
    m_epn[wr_idx] = wr_epn;
    m_rpn[wr_idx] = wr_rpn;
    m_pm[wr_idx]  = wr_perm;
  endtask

  task automatic stage_write(input int idx, input bit v, input bit ts, input logic [7:0] tid,
                             input logic [3:0] sz, input logic [19:0] epn,
                             input logic [19:0] rpn, input logic [5:0] pm);
    wr_en = 1; wr_idx = 5'(idx); wr_valid = v; wr_ts = ts; wr_tid = tid;
    wr_size = sz; wr_epn = epn; wr_rpn = rpn; wr_perm = pm;
  endtask

  task automatic write_entry(input int idx, input bit v, input bit ts, input logic [7:0] tid,
                             input logic [3:0] sz, input logic [19:0] epn,
                             input logic [19:0] rpn, input logic [5:0] pm);
    stage_write(idx, v, ts, tid, sz, epn, rpn, pm);
    @(negedge clk);
    commit();
    wr_en = 0;
  endtask

  function automatic exp_t model(input logic [31:0] ea, input bit instr, input bit is_b,
                                 input bit ds_b, input logic [7:0] pid);
    exp_t e;
    int   cnt = 0;
    e.hit = 0; e.pa = 0; e.perm = 0; e.idx = 0; e.multi = 0;
    for (int i = 0; i < 32; i++) begin
      int sh;
      logic [31:0] base, real_base, low;
      sh = 12 + 2 * ((m_sz[i] > 8) ? 8 : int'(m_sz[i]));
      base = {m_epn[i], 12'h000};
      real_base = {m_rpn[i], 12'h000};
      low = (32'h1 << sh) - 32'h1;
      if (m_v[i] && (m_ts[i] == (instr ? is_b : ds_b)) &&
          (m_tid[i] == 8'h00 || m_tid[i] == pid) && ((ea >> sh) == (base >> sh))) begin
        cnt++;
        if (cnt == 1) begin
          e.hit = 1; e.idx = 5'(i); e.perm = m_pm[i];
          e.pa = (real_base & ~low) | (ea & low);
        end
      end
    end
    e.multi = cnt > 1;
    e.im = !e.hit && instr;
    e.dm = !e.hit && !instr;
    return e;
  endfunction

  task automatic lookup(input logic [31:0] ea, input bit instr, input bit is_b,
                        input bit ds_b, input logic [7:0] pid, input string tag);
    exp_t e;
    req_valid = 1; req_ea = ea; req_instr = instr;
    req_inst_as = is_b; req_data_as = ds_b; req_pid = pid;
    e = model(ea, instr, is_b, ds_b, pid);
    e.tag = tag;
    sbq.push_back(e);
    if (wr_en) commit();
    @(negedge clk);
    req_valid = 0;
    wr_en = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
      if (sbq.size() == 0) begin
        check(0, "R2", "response with no request: act=1 exp=0");
      end else begin
        exp_t e;
        bit ok;
        e = sbq.pop_front();
        ok = (rsp_hit == e.hit) && (rsp_imiss == e.im) && (rsp_dmiss == e.dm) &&
             (rsp_multi == e.multi) && (rsp_pa == e.pa) && (rsp_perm == e.perm) &&
             (!e.hit || rsp_idx == e.idx);
        check(ok, e.tag, $sformatf(
          "act hit=%0b im=%0b dm=%0b multi=%0b idx=%0d pa=%h perm=%h exp hit=%0b im=%0b dm=%0b multi=%0b idx=%0d pa=%h perm=%h",
          rsp_hit, rsp_imiss, rsp_dmiss, rsp_multi, rsp_idx, rsp_pa, rsp_perm,
          e.hit, e.im, e.dm, e.multi, e.idx, e.pa, e.perm));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_v[i] = 0; m_ts[i] = 0; m_tid[i] = 0; m_sz[i] = 0;
      m_epn[i] = 0; m_rpn[i] = 0; m_pm[i] = 0;
    end
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_valid = 0; wr_ts = 0; wr_tid = 0;
    wr_size = 0; wr_epn = 0; wr_rpn = 0; wr_perm = 0;
    req_valid = 0; req_ea = 0; req_instr = 0; req_inst_as = 0; req_data_as = 0; req_pid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid == 0, "R1", $sformatf("rsp_valid after reset act=%0b exp=0", rsp_valid));

    // R1 / R7: empty table misses
    lookup(32'h1000_0ABC, 0, 0, 0, 8'h00, "R1 data miss");
    lookup(32'h1000_0ABC, 1, 0, 0, 8'h00, "R1 R7 instr miss");

    // R4 R11: 4 KB page, space bit 1, any process
    write_entry(3, 1, 1, 8'h00, 4'd0, 20'h10000, 20'h80000, 6'b101010);
    lookup(32'h1000_0ABC, 1, 1, 0, 8'h99, "R4 R11 R6 instr hit");
    // R5: instruction fetch with wrong space bit, data path uses ds
    lookup(32'h1000_0ABC, 1, 0, 1, 8'h00, "R5 R7 instr space mismatch");
    lookup(32'h1000_0123, 0, 0, 1, 8'h00, "R5 data space match");
    lookup(32'h1000_0123, 0, 1, 0, 8'h00, "R5 R7 data space mismatch");

    // R3 R4: 64 KB page, junk in low page-number bits
    write_entry(5, 1, 0, 8'h00, 4'd2, 20'h2003F, 20'h1234F, 6'b000111);
    lookup(32'h2003_ABCD, 0, 0, 0, 8'h05, "R3 R4 64K hit");
    lookup(32'h2004_0000, 0, 0, 0, 8'h05, "R3 64K boundary miss");
    lookup(32'h2002_FFFF, 1, 0, 0, 8'h05, "R3 R7 64K below miss");

    // R3: largest page and size code above 8
    write_entry(7, 1, 0, 8'h00, 4'd8, 20'h30000, 20'hA0000, 6'b110000);
    lookup(32'h3FFF_FFFF, 0, 0, 0, 8'h00, "R3 R4 256M top");
    write_entry(8, 1, 0, 8'h00, 4'd15, 20'h50000, 20'hC0000, 6'b010101);
    lookup(32'h5ABC_DEF0, 0, 0, 0, 8'h00, "R3 code 15 clamps hit");
    lookup(32'h6000_0000, 0, 0, 0, 8'h00, "R3 code 15 clamps miss");

    // R6: owner ID
    write_entry(10, 1, 0, 8'h21, 4'd0, 20'h70001, 20'h11111, 6'b111111);
    lookup(32'h7000_1040, 0, 0, 0, 8'h21, "R6 pid match");
    lookup(32'h7000_1040, 0, 0, 0, 8'h22, "R6 pid mismatch");

    // R8: two overlapping entries
    write_entry(20, 1, 0, 8'h00, 4'd0, 20'h90000, 20'h22222, 6'b000011);
    write_entry(12, 1, 0, 8'h00, 4'd0, 20'h90000, 20'h33333, 6'b001100);
    lookup(32'h9000_0010, 0, 0, 0, 8'h00, "R8 lowest index wins");
    // R10: invalidate 12
    write_entry(12, 0, 0, 8'h00, 4'd0, 20'h90000, 20'h33333, 6'b001100);
    lookup(32'h9000_0010, 0, 0, 0, 8'h00, "R10 R8 single hit after invalidate");

    // R9: write and lookup in the same cycle, then back-to-back lookup
    stage_write(20, 1, 0, 8'h00, 4'd0, 20'h90000, 20'h44444, 6'b100001);
    lookup(32'h9000_0020, 0, 0, 0, 8'h00, "R9 same-cycle sees old entry");
    lookup(32'h9000_0020, 0, 0, 0, 8'h00, "R9 next cycle sees new entry");
    stage_write(20, 0, 0, 8'h00, 4'd0, 20'h90000, 20'h44444, 6'b100001);
    lookup(32'h9000_0030, 1, 0, 0, 8'h00, "R9 same-cycle invalidate still hits");
    lookup(32'h9000_0030, 1, 0, 0, 8'h00, "R9 R10 R7 invalidated misses");

    // R2: idle cycle gives no response
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid == 0, "R2", $sformatf("idle rsp_valid act=%0b exp=0", rsp_valid));
    check(sbq.size() == 0, "R2", $sformatf("pending responses act=%0d exp=0", sbq.size()));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule